// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the slave end of a three-wire serial link made of an enable, a serial clock and one shared data line. The link carries two kinds of command. A 16-bit command reads or writes one byte in a banked register file. A 24-bit command reads two bytes from a four-entry sample buffer that the datapath fills. Every command starts with a header byte that holds a read/write flag, a 3-bit chip identifier and a 4-bit address. The block acts only on commands whose identifier is 110. It drives the data line only while it returns read data.

The serial lines are treated as inputs that are already synchronous to the system clock. Serial clock edges are found by comparing the line with its value one system cycle earlier. The control state machine has five states:
- `ST_IDLE`: enable low.
- `ST_HDR`: collecting header bits 0 to 7.
- `ST_WDATA`: collecting write data bits 8 to 15.
- `ST_RDATA`: returning data from bit 8 onward.
- `ST_SKIP`: the command is rejected or already finished.

Its transitions are as follows:
- IDLE→HDR when enable rises.
- HDR→SKIP on the eighth rising edge if the identifier is wrong.
- HDR→RDATA on that edge if the identifier is correct and the read flag is set.
- HDR→WDATA on that edge if the identifier is correct and the flag is clear.
- WDATA→SKIP on the sixteenth rising edge, which is also when the write commits.
- Any state→IDLE when enable falls.

Top module: `tws_reg_slave`

## Requirements
- R1: After reset, control A reads 0x40, control B reads 0x63, the miscellaneous register reads 0x20, bank 0 is selected, every bank-specific register (addresses 0110 to 1110) reads 0x00, and the data line is not driven.
- R2: A write command places its fields in this bit order: bit 0 is the flag (0 means write), bits 1 to 3 are the ID, bits 4 to 7 are the address with its MSB first, and bits 8 to 15 are the data with its MSB first. The write takes effect on the 16th rising serial clock edge. The value then reads back, and for addresses 0100, 0101 and 1111 it also appears on the matching configuration output.
- R3: A command whose ID field is not 110 changes no register and never drives the data line.
- R4: On a read with a valid ID, the data line is undriven during bits 0 to 7. The block drives it from the falling edge that starts bit 8 and shifts the data out MSB first. It releases the line as soon as enable is low. A write never drives the line.
- R5: When the two low bits of the miscellaneous register are 01, bank 1 is selected. Addresses 0110 to 1110 have separate storage in each bank. Addresses 0100, 0101 and 1111 are shared by both banks.
- R6: Writing the miscellaneous register with bit 7 set returns every register to its R1 value, which also selects bank 0.
- R7: Addresses 0001 and 0011 read as 0x00. Register writes to any address from 0000 to 0011 are ignored.
- R8: A 24-clock read at address 0000 returns entry 0 and then entry 1, each MSB first. The same read at address 0010 returns entry 2 and then entry 3.
- R9: Entry 0 holds the earliest sample written since the last completed 24-clock buffer read. Samples arriving while all four entries are filled are dropped. A completed buffer read makes the next sample land in entry 0.
- R10: A transfer that ends with enable falling before its full bit count changes no register. A buffer read cut short in this way does not restart the buffer order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_en | input | 1 | Transfer enable, high for the whole command |
| ser_clk | input | 1 | Serial clock, idles high |
| ser_din | input | 1 | Data line value as seen at the pad |
| ser_dout | output | 1 | Data line value to drive |
| ser_doe | output | 1 | Output enable for the data line pad |
| smp_valid | input | 1 | Datapath sample write strobe |
| smp_data | input | 8 | Datapath sample value |
| cfg_ctrl_a | output | 8 | Control register A (address 0100) |
| cfg_ctrl_b | output | 8 | Control register B (address 0101) |
| cfg_misc | output | 8 | Miscellaneous register (address 1111) |
| cfg_bank | output | 1 | Selected register bank |

## Verification
The register file is covered by a write-then-read sweep over every address in both banks. Each address gets a value computed from the address, which separates per-bank storage from shared storage and exposes ignored and unused addresses. A sweep over all eight ID codes, applied to both writes and reads, shows that only one code is accepted and that a rejected code never drives the line. A sequence of sample pushes, full buffer reads and deliberately truncated reads distinguishes dropping a sample from wrapping over old entries. It also distinguishes a completed buffer read from an aborted one. A soft reset issued while bank 1 is selected shows that the defaults return in both banks.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int ADDR_W = 4;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } link_state_t;

    localparam logic [ADDR_W-1:0] A_BUF_LO = 4'h0;
    localparam logic [ADDR_W-1:0] A_UNUSED0 = 4'h1;
    localparam logic [ADDR_W-1:0] A_BUF_HI = 4'h2;
    localparam logic [ADDR_W-1:0] A_UNUSED1 = 4'h3;
    localparam logic [ADDR_W-1:0] A_CTRL_A = 4'h4;
    localparam logic [ADDR_W-1:0] A_CTRL_B = 4'h5;
    localparam logic [ADDR_W-1:0] A_MISC   = 4'hF;

endpackage

// File: rtl/tws_link_fsm.sv
module tws_link_fsm
    import tws_pkg::*;
#(
    parameter logic [2:0] CHIP_ID  = 3'b110,
    parameter int         HDR_BITS = 8,
    parameter int         REG_BITS = 16,
    parameter int         BUF_BITS = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_en,
    input  logic                 ser_clk,
    input  logic                 ser_din,
    output logic                 ser_dout,
    output logic                 ser_doe,
    output logic [ADDR_W-1:0]    rd_addr,
    input  logic [2*BYTE_W-1:0]  rd_data,
    output logic                 wr_stb,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [BYTE_W-1:0]    wr_data,
    output logic                 buf_clr
);

    localparam int               CNT_W     = $clog2(BUF_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] HDR_DONE  = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] REG_LAST  = CNT_W'(REG_BITS - 1);
    localparam logic [CNT_W-1:0] BUF_LAST  = CNT_W'(BUF_BITS - 1);
    localparam int               SHR_W     = 2 * BYTE_W;

    link_state_t          state_q, state_d;
    logic                 sclk_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [BYTE_W-2:0]    rx_q;
    logic [BYTE_W-1:0]    hdr_q;
    logic [SHR_W-1:0]     shr_q;
    logic                 oe_q;

    logic                 rise, fall;
    logic [BYTE_W-1:0]    hdr_next;
    logic                 last_hdr;
    logic                 id_ok;
    logic                 is_buf_addr;

    // serial clock edges, seen only inside a transfer
    assign rise     = ser_en &  ser_clk & ~sclk_q;
    assign fall     = ser_en & ~ser_clk &  sclk_q;
    assign hdr_next = {rx_q, ser_din};
    assign last_hdr = rise && (state_q == ST_HDR) && (cnt_q == HDR_LAST);
    assign id_ok    = (hdr_next[6:4] == CHIP_ID);
    assign is_buf_addr = (hdr_q[3:0] == A_BUF_LO) || (hdr_q[3:0] == A_BUF_HI);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!ser_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_HDR;
                ST_HDR: begin
                    if (last_hdr) begin
                        if (!id_ok)          state_d = ST_SKIP;
                        else if (hdr_next[7]) state_d = ST_RDATA;
                        else                 state_d = ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (rise && cnt_q == REG_LAST) state_d = ST_SKIP;
                end
                ST_RDATA: state_d = ST_RDATA;
                ST_SKIP:  state_d = ST_SKIP;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_stb   = (state_q == ST_WDATA) && rise && (cnt_q == REG_LAST);
        wr_addr  = hdr_q[3:0];
        wr_data  = hdr_next;
        rd_addr  = hdr_next[3:0];
        buf_clr  = (state_q == ST_RDATA) && rise && (cnt_q == BUF_LAST) && is_buf_addr;
        ser_dout = shr_q[SHR_W-1];
        ser_doe  = oe_q & ser_en;
    end

    // datapath registers of the link
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            cnt_q  <= '0;
            rx_q   <= '0;
            hdr_q  <= '0;
            shr_q  <= '0;
            oe_q   <= 1'b0;
        end else begin
            sclk_q <= ser_clk;
            if (!ser_en || state_q == ST_IDLE) begin
                cnt_q <= '0;
                oe_q  <= 1'b0;
            end else begin
                if (rise) begin
                    rx_q  <= hdr_next[BYTE_W-2:0];
                    cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
                end
                if (last_hdr) begin
                    hdr_q <= hdr_next;
                    if (id_ok && hdr_next[7]) begin
                        shr_q <= rd_data;
                    end
                end
                if (fall && state_q == ST_RDATA) begin
                    if (!oe_q) oe_q  <= 1'b1;
                    else       shr_q <= {shr_q[SHR_W-2:0], 1'b0};
                end
            end
        end
    end

    // R4
    oe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> (state_q == ST_RDATA) && hdr_q[7]);

    // R4
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> (cnt_q == HDR_DONE));

    // R3
    wr_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (hdr_q[6:4] == CHIP_ID) && !hdr_q[7]);

    // R3
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !oe_q);

endmodule

// File: rtl/tws_regfile.sv
module tws_regfile
    import tws_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CTRL_A_RST = 8'h40,
    parameter logic [BYTE_W-1:0] CTRL_B_RST = 8'h63,
    parameter logic [BYTE_W-1:0] MISC_RST   = 8'h20,
    parameter logic [1:0]        BANK1_CODE = 2'b01,
    parameter logic [ADDR_W-1:0] LO_ADDR    = 4'h6,
    parameter logic [ADDR_W-1:0] HI_ADDR    = 4'hE,
    parameter int                BANKS      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ctrl_a,
    output logic [BYTE_W-1:0] ctrl_b,
    output logic [BYTE_W-1:0] misc,
    output logic              bank
);

    localparam int N_BANKED = int'(HI_ADDR) - int'(LO_ADDR) + 1;

    logic [BYTE_W-1:0] mem_q [BANKS][N_BANKED];
    logic [BYTE_W-1:0] ctrl_a_q, ctrl_b_q, misc_q;
    logic              soft_rst;
    logic              wr_banked, rd_banked;
    logic [ADDR_W-1:0] wr_idx, rd_idx;

    assign bank      = (misc_q[1:0] == BANK1_CODE);
    assign soft_rst  = wr_en && (wr_addr == A_MISC) && wr_data[BYTE_W-1];
    assign wr_banked = (wr_addr >= LO_ADDR) && (wr_addr <= HI_ADDR);
    assign rd_banked = (rd_addr >= LO_ADDR) && (rd_addr <= HI_ADDR);
    assign wr_idx    = wr_addr - LO_ADDR;
    assign rd_idx    = rd_addr - LO_ADDR;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_a_q <= CTRL_A_RST;
            ctrl_b_q <= CTRL_B_RST;
            misc_q   <= MISC_RST;
            for (int b = 0; b < BANKS; b++)
                for (int k = 0; k < N_BANKED; k++)
                    mem_q[b][k] <= '0;
        end else if (soft_rst) begin
            ctrl_a_q <= CTRL_A_RST;
            ctrl_b_q <= CTRL_B_RST;
            misc_q   <= MISC_RST;
            for (int b = 0; b < BANKS; b++)
                for (int k = 0; k < N_BANKED; k++)
                    mem_q[b][k] <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL_A)      ctrl_a_q <= wr_data;
            else if (wr_addr == A_CTRL_B) ctrl_b_q <= wr_data;
            else if (wr_addr == A_MISC)   misc_q   <= wr_data;
            else if (wr_banked)           mem_q[bank][wr_idx] <= wr_data;
        end
    end

    always_comb begin
        if (rd_addr == A_CTRL_A)      rd_data = ctrl_a_q;
        else if (rd_addr == A_CTRL_B) rd_data = ctrl_b_q;
        else if (rd_addr == A_MISC)   rd_data = misc_q;
        else if (rd_banked)           rd_data = mem_q[bank][rd_idx];
        else                          rd_data = '0;
    end

    assign ctrl_a = ctrl_a_q;
    assign ctrl_b = ctrl_b_q;
    assign misc   = misc_q;

    // R6
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctrl_a_q == CTRL_A_RST) && (ctrl_b_q == CTRL_B_RST)
                     && (misc_q == MISC_RST) && !bank);

    // R7
    low_addr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr < A_CTRL_A) |=>
            $stable(ctrl_a_q) && $stable(ctrl_b_q) && $stable(misc_q));

    // R2
    ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL_A) |=> (ctrl_a_q == $past(wr_data)));

endmodule

// File: rtl/tws_sample_buf.sv
module tws_sample_buf #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [W-1:0]     smp_data,
    input  logic             buf_clr,
    output logic [DEPTH*W-1:0] entries
);

    localparam int               FILL_W = $clog2(DEPTH + 1);
    localparam logic [FILL_W-1:0] FULL  = FILL_W'(DEPTH);

    logic [FILL_W-1:0] fill_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (buf_clr) begin
            fill_q <= smp_valid ? FILL_W'(1) : '0;
        end else if (smp_valid && fill_q != FULL) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [W-1:0] ent_q;
        logic         hit;
        assign hit = smp_valid && (buf_clr ? (i == 0) : (fill_q == FILL_W'(i)));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ent_q <= '0;
            else if (hit) ent_q <= smp_data;
        end
        assign entries[i*W +: W] = ent_q;
    end

    // R9
    fill_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_clr |=> (fill_q <= FILL_W'(1)));

    // R9
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == FULL && !buf_clr) |=> (fill_q == FULL) && $stable(entries));

endmodule

// File: rtl/tws_reg_slave.sv
module tws_reg_slave
    import tws_pkg::*;
#(
    parameter logic [2:0] CHIP_ID   = 3'b110,
    parameter int         BUF_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_en,
    input  logic        ser_clk,
    input  logic        ser_din,
    output logic        ser_dout,
    output logic        ser_doe,
    input  logic        smp_valid,
    input  logic [7:0]  smp_data,
    output logic [7:0]  cfg_ctrl_a,
    output logic [7:0]  cfg_ctrl_b,
    output logic [7:0]  cfg_misc,
    output logic        cfg_bank
);

    localparam int W = BYTE_W;

    logic [ADDR_W-1:0]      rd_addr;
    logic [2*W-1:0]         rd_word;
    logic [W-1:0]           reg_rd;
    logic                   wr_stb;
    logic [ADDR_W-1:0]      wr_addr;
    logic [W-1:0]           wr_data;
    logic                   buf_clr;
    logic [BUF_DEPTH*W-1:0] entries;

    tws_link_fsm #(
        .CHIP_ID (CHIP_ID),
        .HDR_BITS(8),
        .REG_BITS(16),
        .BUF_BITS(24)
    ) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_en  (ser_en),
        .ser_clk (ser_clk),
        .ser_din (ser_din),
        .ser_dout(ser_dout),
        .ser_doe (ser_doe),
        .rd_addr (rd_addr),
        .rd_data (rd_word),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .buf_clr (buf_clr)
    );

    tws_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_stb),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(reg_rd),
        .ctrl_a (cfg_ctrl_a),
        .ctrl_b (cfg_ctrl_b),
        .misc   (cfg_misc),
        .bank   (cfg_bank)
    );

    tws_sample_buf #(
        .DEPTH(BUF_DEPTH),
        .W    (W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .buf_clr  (buf_clr),
        .entries  (entries)
    );

    // read word: buffer pairs at their two addresses, one byte otherwise
    always_comb begin
        if (rd_addr == A_BUF_LO)
            rd_word = {entries[0*W +: W], entries[1*W +: W]};
        else if (rd_addr == A_BUF_HI)
            rd_word = {entries[2*W +: W], entries[3*W +: W]};
        else
            rd_word = {reg_rd, {W{1'b0}}};
    end

endmodule

// File: tb/tws_reg_slave_test.sv
module tws_reg_slave_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       ser_en = 1'b0, ser_clk = 1'b1, ser_din = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_data = 8'h00;
    logic       ser_dout, ser_doe, cfg_bank;
    logic [7:0] cfg_ctrl_a, cfg_ctrl_b, cfg_misc;

    tws_reg_slave uut (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
        .ser_din(ser_din), .ser_dout(ser_dout), .ser_doe(ser_doe),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_ctrl_a(cfg_ctrl_a), .cfg_ctrl_b(cfg_ctrl_b),
        .cfg_misc(cfg_misc), .cfg_bank(cfg_bank)
    );

    int  n_run = 0, n_fail = 0;
    bit  finished = 1'b0;

    // reference model
    logic [7:0] m_a, m_b, m_misc;
    logic [7:0] m_mem [2][16];
    logic [7:0] m_buf [4];
    int         m_fill;

    logic [23:0] rxb, oeb;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic m_bank();
        return m_misc[1:0] == 2'b01;
    endfunction

    function automatic void m_defaults();
        m_a = 8'h40; m_b = 8'h63; m_misc = 8'h20;
        for (int b = 0; b < 2; b++)
            for (int k = 0; k < 16; k++) m_mem[b][k] = 8'h00;
    endfunction

    function automatic void m_write(input logic [3:0] a, input logic [7:0] d);
        if (a == 4'hF && d[7]) m_defaults();
        else if (a == 4'h4) m_a = d;
        else if (a == 4'h5) m_b = d;
        else if (a == 4'hF) m_misc = d;
        else if (a >= 4'h6 && a <= 4'hE) m_mem[m_bank()][a] = d;
    endfunction

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a)
            4'h0: return m_buf[0];
            4'h2: return m_buf[2];
            4'h1, 4'h3: return 8'h00;
            4'h4: return m_a;
            4'h5: return m_b;
            4'hF: return m_misc;
            default: return m_mem[m_bank()][a];
        endcase
    endfunction

    task automatic xfer(input int n, input logic [23:0] fr);
        rxb = '0; oeb = '0;
        @(negedge clk) ser_en = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            ser_clk = 1'b0; ser_din = fr[23-i];
            repeat (2) @(negedge clk);
            rxb[23-i] = ser_dout; oeb[23-i] = ser_doe;
            ser_clk = 1'b1;
            repeat (2) @(negedge clk);
        end
        ser_en = 1'b0; ser_din = 1'b0;
        @(negedge clk);
    endtask

    task automatic wreg(input logic [3:0] a, input logic [7:0] d,
                        input logic [2:0] id, input int n);
        xfer(n, {1'b0, id, a, d, 8'h00});
    endtask

    task automatic rreg(input logic [3:0] a, output logic [7:0] d);
        xfer(16, {1'b1, 3'b110, a, 16'h0000});
        d = rxb[15:8];
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk) smp_valid = 1'b1; smp_data = d;
        @(negedge clk) smp_valid = 1'b0;
        if (m_fill < 4) begin m_buf[m_fill] = d; m_fill++; end
    endtask

    task automatic rbuf(input logic [3:0] a, input string req);
        int base;
        base = (a == 4'h2) ? 2 : 0;
        xfer(24, {1'b1, 3'b110, a, 16'h0000});
        chk(req, rxb[15:0], {m_buf[base], m_buf[base+1]});
        m_fill = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        m_defaults();
        for (int k = 0; k < 4; k++) m_buf[k] = 8'h00;
        m_fill = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctrl_a", cfg_ctrl_a, 8'h40);
        chk("R1 ctrl_b", cfg_ctrl_b, 8'h63);
        chk("R1 misc", cfg_misc, 8'h20);
        chk("R1 bank", cfg_bank, 1'b0);
        chk("R1 doe", ser_doe, 1'b0);
        for (int a = 6; a <= 14; a++) begin
            rreg(4'(a), rd);
            chk("R1 banked default", rd, 8'h00);
        end

        // R2 / R7 bank 0 sweep
        for (int a = 0; a <= 14; a++) begin
            logic [7:0] d;
            d = 8'(a * 29 + 7);
            wreg(4'(a), d, 3'b110, 16);
            chk("R4 write never drives", oeb, 24'h0);
            m_write(4'(a), d);
        end
        chk("R2 ctrl_a port", cfg_ctrl_a, m_a);
        chk("R2 ctrl_b port", cfg_ctrl_b, m_b);
        for (int a = 0; a <= 15; a++) begin
            rreg(4'(a), rd);
            if (a < 4) chk("R7 low address", rd, m_read(4'(a)));
            else       chk("R2 readback", rd, m_read(4'(a)));
        end

        // R4 drive window and release
        rreg(4'h4, rd);
        chk("R4 header undriven", oeb[23:16], 8'h00);
        chk("R4 driven from bit 8", oeb[15:8], 8'hFF);
        chk("R4 released", ser_doe, 1'b0);

        // R5 bank switch
        wreg(4'hF, 8'h01, 3'b110, 16); m_write(4'hF, 8'h01);
        chk("R5 bank1 selected", cfg_bank, 1'b1);
        for (int a = 6; a <= 14; a++) begin
            logic [7:0] d;
            d = 8'(a * 53 + 100);
            wreg(4'(a), d, 3'b110, 16);
            m_write(4'(a), d);
        end
        for (int a = 4; a <= 15; a++) begin
            rreg(4'(a), rd);
            chk("R5 bank1 read", rd, m_read(4'(a)));
        end
        wreg(4'hF, 8'h00, 3'b110, 16); m_write(4'hF, 8'h00);
        chk("R5 bank0 selected", cfg_bank, 1'b0);
        for (int a = 6; a <= 14; a++) begin
            rreg(4'(a), rd);
            chk("R5 bank0 kept", rd, m_read(4'(a)));
        end

        // R3 ID sweep
        for (int id = 0; id < 8; id++) begin
            logic [7:0] d;
            d = 8'hA0 | 8'(id);
            wreg(4'h4, d, 3'(id), 16);
            if (id == 6) m_write(4'h4, d);
            chk("R3 id write", cfg_ctrl_a, m_a);
            xfer(16, {1'b1, 3'(id), 4'h4, 16'h0000});
            if (id == 6) chk("R3 good id drives", oeb[15:8], 8'hFF);
            else         chk("R3 bad id quiet", oeb, 24'h0);
        end

        // R10 truncated writes
        wreg(4'h5, 8'h11, 3'b110, 8);
        chk("R10 cut at 8", cfg_ctrl_b, m_b);
        wreg(4'h5, 8'h22, 3'b110, 12);
        chk("R10 cut at 12", cfg_ctrl_b, m_b);
        wreg(4'h5, 8'h33, 3'b110, 15);
        chk("R10 cut at 15", cfg_ctrl_b, m_b);
        xfer(10, {1'b1, 3'b110, 4'h4, 16'h0});
        chk("R4 released after cut read", ser_doe, 1'b0);

        // R8 / R9 sample buffer
        for (int k = 1; k <= 5; k++) push(8'(k * 17));
        rreg(4'h0, rd);
        chk("R9 oldest first, extra dropped", rd, m_buf[0]);
        rbuf(4'h2, "R8 second pair");
        push(8'hC6); push(8'h39);
        rbuf(4'h0, "R9 restart after read");
        push(8'h5D); push(8'hE2);
        xfer(20, {1'b1, 3'b110, 4'h0, 16'h0});
        push(8'h7A); push(8'h84);
        rbuf(4'h0, "R10 cut buffer read keeps order");
        rbuf(4'h2, "R8 first and second pair");

        // R6 soft reset from bank 1
        wreg(4'hF, 8'h01, 3'b110, 16); m_write(4'hF, 8'h01);
        wreg(4'h7, 8'h3C, 3'b110, 16); m_write(4'h7, 8'h3C);
        wreg(4'h4, 8'h99, 3'b110, 16); m_write(4'h4, 8'h99);
        wreg(4'hF, 8'h80, 3'b110, 16); m_write(4'hF, 8'h80);
        chk("R6 ctrl_a", cfg_ctrl_a, 8'h40);
        chk("R6 ctrl_b", cfg_ctrl_b, 8'h63);
        chk("R6 misc", cfg_misc, 8'h20);
        chk("R6 bank", cfg_bank, 1'b0);
        rreg(4'h7, rd);
        chk("R6 bank0 cleared", rd, 8'h00);
        wreg(4'hF, 8'h01, 3'b110, 16); m_write(4'hF, 8'h01);
        rreg(4'h7, rd);
        chk("R6 bank1 cleared", rd, 8'h00);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule